// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits between the conversion core of a two-channel sampling converter and its output pins. Each cycle that the core marks as valid, it takes an 11-bit raw result per channel: a top flag bit that signals the input went past positive full scale, and ten magnitude bits. It registers a formatted word for each channel. A single format-select input applies to both channels. With select low, the word is offset (straight) binary. With select high, the most significant data bit is inverted, which gives two's complement.

An overrange result forces all ten data bits to one, and this forcing comes before the inversion. In two's complement an overrange word therefore reads as the largest positive code with the flag set. An active-low output enable is brought out as one drive-enable per channel, so the pads can be tri-stated outside the block. A registered data-valid strobe marks each cycle in which fresh words sit on the bus.

Top module: `adcfmt_top`

## Requirements
- R1: An asserted `rst` (active high, asynchronous) clears every output word to zero and drives `dav_o` low at once, without waiting for a clock edge.
- R2: With `twos_sel_i` low and flag bit 10 of a channel's raw word clear, that channel's output bits 9..0 equal the raw bits 9..0 and output bit 10 is 0, after the clock edge that loads it.
- R3: With `twos_sel_i` high and the flag clear, output bit 9 is the inverse of raw bit 9, bits 8..0 are copied unchanged, and bit 10 is 0. Example: raw 0x000 gives 0x200 and raw 0x200 gives 0x000.
- R4: With the flag (raw bit 10) set and `twos_sel_i` low, the output word is 0x7FF, whatever the raw bits 9..0 hold.
- R5: With the flag set and `twos_sel_i` high, the forcing is applied before the inversion, so the output word is 0x5FF (flag 1, bit 9 is 0, bits 8..0 are 1).
- R6: A word is loaded on a rising edge where `raw_vld_i` is high. `dav_o` is high for the cycle after every edge with `raw_vld_i` high and low after every edge with it low.
- R7: On edges with `raw_vld_i` low, the output words hold their value. Changes to the raw inputs or to `twos_sel_i` have no effect on them.
- R8: `drive_en_o` has every bit at 1 while `oe_n_i` is low and every bit at 0 while it is high, with no clock delay. The enable leaves the data words and `dav_o` untouched.
- R9: Both channels are formatted in the same cycle under the one shared select. Each channel's word depends only on its own raw slice: channel 0 in bits 10..0 and channel 1 in bits 21..11 of the packed buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on the rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| raw_vld_i | input | 1 | Raw results present this cycle |
| raw_i | input | NCH*(DW+1) | Packed raw results, channel 0 in the low slice, flag on top of each slice |
| twos_sel_i | input | 1 | 0 gives straight binary, 1 gives two's complement |
| oe_n_i | input | 1 | Output enable, active low |
| word_o | output | NCH*(DW+1) | Registered formatted words, same packing as raw_i |
| drive_en_o | output | NCH | Per-channel pad drive enable; 0 means high impedance |
| dav_o | output | 1 | Data valid, high for the cycle after a load |

## Verification
A table of raw words is applied to both channels under each format setting. Negative full scale, mid-scale and positive full scale show whether the bit-9 inversion is right in both directions. An overrange word with zero data bits and one with scrambled data bits shows whether the forcing ignores the magnitude and comes before the inversion. Each vector pairs different values on the two channels, so a swapped or shared slice shows up. Directed steps then vary the inputs while valid is low to show the words hold. They toggle the enable to show the drive changes without the data changing. They assert reset mid-cycle to show the clear does not wait for a clock edge.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  typedef enum logic {
    FMT_STRAIGHT = 1'b0,
    FMT_TWOS     = 1'b1
  } fmt_e;

  localparam int DEF_NCH = 2;
  localparam int DEF_DW  = 10;
endpackage

// File: rtl/adcfmt_lane.sv
module adcfmt_lane
  import adcfmt_pkg::*;
#(
  parameter int DW = adcfmt_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          twos_i,
  input  logic [DW:0]   raw_i,
  output logic [DW:0]   word_o
);
  localparam int WW = DW + 1;

  // Forcing comes first, inversion second.
  function automatic logic [DW:0] shape_word(input logic [DW:0] raw, input fmt_e fmt);
    logic [DW-1:0] mag;
    mag = raw[DW] ? {DW{1'b1}} : raw[DW-1:0];
    if (fmt == FMT_TWOS) mag[DW-1] = ~mag[DW-1];
    return {raw[DW], mag};
  endfunction

  fmt_e          fmt_w;
  logic          ovr_w;
  logic [WW-1:0] shaped_w;
  logic [WW-1:0] word_q;

  assign fmt_w    = fmt_e'(twos_i);
  assign ovr_w    = raw_i[DW];
  assign shaped_w = shape_word(raw_i, fmt_w);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         word_q <= '0;
    else if (load_i) word_q <= shaped_w;
  end

  assign word_o = word_q;

  // R2
  bin_pass_chk: assert property (@(posedge clk) disable iff (rst)
    load_i && !ovr_w && !twos_i |=> word_q == {1'b0, $past(raw_i[DW-1:0])});

  // R3
  twos_flip_chk: assert property (@(posedge clk) disable iff (rst)
    load_i && !ovr_w && twos_i |=>
      (word_q[DW] == 1'b0) && (word_q[DW-1] != $past(raw_i[DW-1])) &&
      (word_q[DW-2:0] == $past(raw_i[DW-2:0])));

  // R4
  ovr_force_chk: assert property (@(posedge clk) disable iff (rst)
    load_i && ovr_w && !twos_i |=> &word_q);

  // R5
  ovr_twos_chk: assert property (@(posedge clk) disable iff (rst)
    load_i && ovr_w && twos_i |=> word_q == {2'b10, {(DW-1){1'b1}}});

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(word_q));
endmodule

// File: rtl/adcfmt_valid.sv
module adcfmt_valid (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic dav_o
);
  logic dav_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) dav_q <= 1'b0;
    else     dav_q <= load_i;
  end

  assign dav_o = dav_q;

  // R6
  dav_rise_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> dav_q);

  // R6
  dav_low_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> !dav_q);
endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top
  import adcfmt_pkg::*;
#(
  parameter int NCH = adcfmt_pkg::DEF_NCH,
  parameter int DW  = adcfmt_pkg::DEF_DW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  raw_vld_i,
  input  logic [NCH*(DW+1)-1:0] raw_i,
  input  logic                  twos_sel_i,
  input  logic                  oe_n_i,
  output logic [NCH*(DW+1)-1:0] word_o,
  output logic [NCH-1:0]        drive_en_o,
  output logic                  dav_o
);
  localparam int WW = DW + 1;

  logic load_w;
  assign load_w = raw_vld_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    adcfmt_lane #(.DW(DW)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load_i (load_w),
      .twos_i (twos_sel_i),
      .raw_i  (raw_i[ch*WW +: WW]),
      .word_o (word_o[ch*WW +: WW])
    );
  end

  adcfmt_valid u_valid (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_w),
    .dav_o  (dav_o)
  );

  assign drive_en_o = oe_n_i ? '0 : '1;

  // R8
  always_comb begin
    oe_drive_chk: assert ($onehot0(drive_en_o ^ {NCH{~oe_n_i}}) || rst || 1'b1 ? (drive_en_o != '0) == !oe_n_i : 1'b1);
  end
endmodule

// File: tb/adcfmt_top_test.sv
module adcfmt_top_test;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raw_vld_i = 1'b0;
  logic [21:0] raw_i = '0;
  logic        twos_sel_i = 1'b0;
  logic        oe_n_i = 1'b0;
  logic [21:0] word_o;
  logic [1:0]  drive_en_o;
  logic        dav_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  adcfmt_top uut (
    .clk(clk), .rst(rst), .raw_vld_i(raw_vld_i), .raw_i(raw_i),
    .twos_sel_i(twos_sel_i), .oe_n_i(oe_n_i), .word_o(word_o),
    .drive_en_o(drive_en_o), .dav_o(dav_o)
  );

  // {select, raw channel 0, raw channel 1}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 11'h000, 11'h3FF},
    {1'b0, 11'h200, 11'h1FF},
    {1'b1, 11'h000, 11'h200},
    {1'b1, 11'h3FF, 11'h155},
    {1'b0, 11'h400, 11'h123},
    {1'b1, 11'h400, 11'h5AA},
    {1'b0, 11'h7FF, 11'h001},
    {1'b1, 11'h0AB, 11'h7FF}
  };

  function automatic int expect_word(input int raw, input bit sel);
    int flag = raw / 1024;
    int mag  = raw % 1024;
    if (flag != 0) mag = 1023;
    if (sel) mag = (mag + 512) % 1024;
    return flag * 1024 + mag;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [10:0] raw, input bit sel);
    if (raw[10]) return sel ? "R5" : "R4";
    return sel ? "R3" : "R2";
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [21:0] held;
    #(CLK_P*2 + 3);
    // R1 state while reset held
    chk("R1 word", int'(word_o), 0);
    chk("R1 dav", int'(dav_o), 0);
    @(negedge clk);
    rst = 1'b0;

    // main table, R9 per-channel slices
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      twos_sel_i = VEC[i][22];
      raw_i      = {VEC[i][10:0], VEC[i][21:11]};
      raw_vld_i  = 1'b1;
      @(negedge clk);
      chk({tag_for(VEC[i][21:11], VEC[i][22]), " R9 ch0"}, int'(word_o[10:0]),
          expect_word(int'(VEC[i][21:11]), VEC[i][22]));
      chk({tag_for(VEC[i][10:0], VEC[i][22]), " R9 ch1"}, int'(word_o[21:11]),
          expect_word(int'(VEC[i][10:0]), VEC[i][22]));
      chk("R6 dav high", int'(dav_o), 1);
    end

    // R7 hold with valid low
    held = word_o;
    raw_vld_i  = 1'b0;
    raw_i      = 22'h155555;
    twos_sel_i = ~twos_sel_i;
    @(negedge clk);
    chk("R7 hold", int'(word_o), int'(held));
    chk("R6 dav low", int'(dav_o), 0);
    @(negedge clk);
    chk("R7 hold second", int'(word_o), int'(held));

    // R8 enable
    chk("R8 drive on", int'(drive_en_o), 3);
    oe_n_i = 1'b1;
    #1;
    chk("R8 drive off", int'(drive_en_o), 0);
    chk("R8 data kept", int'(word_o), int'(held));
    chk("R8 dav kept", int'(dav_o), 0);
    oe_n_i = 1'b0;
    #1;
    chk("R8 drive back", int'(drive_en_o), 3);

    // R1 asynchronous reset mid-cycle
    @(negedge clk);
    raw_vld_i = 1'b1;
    raw_i     = {11'h0F0, 11'h30F};
    twos_sel_i = 1'b0;
    @(negedge clk);
    chk("R6 dav before reset", int'(dav_o), 1);
    chk("R2 word before reset", int'(word_o), int'({11'h0F0, 11'h30F}));
    rst = 1'b1;
    #1;
    chk("R1 async word", int'(word_o), 0);
    chk("R1 async dav", int'(dav_o), 0);
    raw_vld_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 stays clear", int'(word_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule